// File: doc/BRIEF.md
# Bus Cycle Response Timeout Monitor

This block watches bus cycles and guards the processor against a cycle that never ends. When a cycle is admitted for monitoring, a counter advances once per system clock. It stops when the responder ends the cycle with a data-size acknowledge or an autovector response. If no such response arrives within the selected limit, the block raises a single-clock internal bus-error pulse and returns to idle.

The limit comes from a two-bit timing code that is captured when a cycle is admitted. Cycles on the internal bus are always watched. Cycles routed to the external bus are watched only when the external-watch enable is set, and only when the processor itself started them. A word transfer to an 8-bit port is carried out as two byte accesses. The block treats that pair as one transaction: the first acknowledge does not stop or restart the count, and only the second one ends it.

Top module: `bus_watchdog`

## Requirements
- R1: Timing code 00 selects 64 clocks, 01 selects 32, 10 selects 16 and 11 selects 8. If a monitored cycle is admitted at clock edge E0 and no terminating response arrives on edges E1..EN (N being the limit), `berr` is high for the clock that follows edge EN.
- R2: A terminating response sampled on any edge E1..EN, including the last allowed edge EN, ends the transaction without an error.
- R3: `berr` is a one-clock pulse, and at most one pulse is issued per monitored transaction.
- R4: A cycle with `cyc_ext`=0 (internal bus) is monitored whatever the values of `ext_watch_en` and `cyc_by_cpu`.
- R5: A cycle with `cyc_ext`=1 and `cyc_by_cpu`=1 is monitored only when `ext_watch_en`=1. When `ext_watch_en`=0, such a cycle never produces `berr`.
- R6: A cycle with `cyc_ext`=1 and `cyc_by_cpu`=0 (started by another master) is never monitored.
- R7: When `cyc_word`=1 and `port_8bit`=1, the first `ack` does not clear the counter. The count runs across both byte accesses, and only the second `ack` terminates the transaction. For any other width combination, one `ack` terminates it.
- R8: A change to `tmo_sel` while a transaction is being timed has no effect on that transaction's limit.
- R9: A `cyc_start` pulse that arrives while a transaction is being timed is ignored and does not restart the count.
- R10: Synchronous reset `rst` clears the monitor. `berr` is low during reset, and a transaction in progress when reset is asserted produces no error afterwards.
- R11: `autovec` terminates a monitored transaction at once, including a split byte-pair transfer whose second `ack` has not yet arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_sel | input | 2 | Timeout code (00=64, 01=32, 10=16, 11=8 clocks) |
| ext_watch_en | input | 1 | Enables timing of processor cycles on the external bus |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cyc_ext | input | 1 | 1 = cycle targets the external bus, 0 = internal bus |
| cyc_by_cpu | input | 1 | 1 = cycle was started by the processor, 0 = by another master |
| cyc_word | input | 1 | 1 = word-sized transfer |
| port_8bit | input | 1 | 1 = addressed port is 8 bits wide |
| ack | input | 1 | Data-size acknowledge strobe |
| autovec | input | 1 | Autovector response strobe |
| berr | output | 1 | One-clock internal bus-error pulse |

## Verification
Every timing code is tried with four response patterns: no response at all, a response one clock before the limit, a response exactly on the last allowed clock, and a response one clock too late. Together these separate an off-by-one in the comparison from a wrong code mapping. The admission matrix sweeps target, initiator and enable, showing which combinations are timed. Split byte-pair transfers are run with halves that are each shorter than the limit but longer in total, which exposes a counter that clears on the first acknowledge. Mid-count changes to the timing code, stray start strobes, autovector endings and a reset inside a transaction check that the limit and count stay tied to the transaction that set them.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

    typedef enum logic [1:0] {
        TMO_LONGEST = 2'b00,
        TMO_LONG    = 2'b01,
        TMO_SHORT   = 2'b10,
        TMO_SHORTEST= 2'b11
    } tmo_code_e;

    typedef struct packed {
        logic      split;
        tmo_code_e code;
    } txn_cfg_t;

    // Number of clocks allowed for a code; base is the shortest limit.
    function automatic int unsigned tmo_clocks(input tmo_code_e code, input int unsigned base);
        case (code)
            TMO_LONGEST:  return base * 8;
            TMO_LONG:     return base * 4;
            TMO_SHORT:    return base * 2;
            default:      return base;
        endcase
    endfunction

endpackage

// File: rtl/bmon_admit.sv
module bmon_admit
    import bmon_pkg::*;
(
    input  logic       cyc_start,
    input  logic       cyc_ext,
    input  logic       cyc_by_cpu,
    input  logic       ext_watch_en,
    input  logic       cyc_word,
    input  logic       port_8bit,
    input  logic [1:0] tmo_sel,
    output logic       take,
    output txn_cfg_t   cfg
);

    logic watched;

    always_comb begin
        watched   = !cyc_ext || (cyc_by_cpu && ext_watch_en);
        take      = cyc_start && watched;
        cfg.split = cyc_word && port_8bit;
        cfg.code  = tmo_code_e'(tmo_sel);
    end

endmodule

// File: rtl/bmon_pair_track.sv
module bmon_pair_track (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic active,
    input  logic split,
    input  logic ack,
    input  logic autovec,
    output logic fin
);

    logic half_q;

    always_comb begin
        fin = active && (autovec || (ack && (!split || half_q)));
    end

    always_ff @(posedge clk) begin
        if (rst || load || !active) begin
            half_q <= 1'b0;
        end else if (split && ack && !autovec && !half_q) begin
            half_q <= 1'b1;
        end
    end

    // R7
    half_needs_split_chk: assert property (@(posedge clk) disable iff (rst)
        half_q |-> split);

endmodule

// File: rtl/bmon_timer.sv
module bmon_timer
    import bmon_pkg::*;
#(
    parameter int unsigned BASE_CLOCKS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  txn_cfg_t cfg,
    input  logic     fin,
    output logic     active,
    output logic     load,
    output logic     split,
    output logic     berr
);

    localparam int unsigned MAX_CLOCKS = BASE_CLOCKS * 8;
    localparam int unsigned CW = $clog2(MAX_CLOCKS);

    logic          active_q;
    logic          split_q;
    logic          berr_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;

    always_comb begin
        load   = take && !active_q;
        active = active_q;
        split  = split_q;
        berr   = berr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            split_q  <= 1'b0;
            berr_q   <= 1'b0;
            cnt_q    <= '0;
            last_q   <= '0;
        end else begin
            berr_q <= 1'b0;
            if (!active_q) begin
                if (take) begin
                    active_q <= 1'b1;
                    cnt_q    <= '0;
                    last_q   <= CW'(tmo_clocks(cfg.code, BASE_CLOCKS) - 1);
                    split_q  <= cfg.split;
                end
            end else if (fin) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else if (cnt_q == last_q) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
                berr_q   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R3
    berr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        berr_q |=> !berr_q);

    // R3
    berr_ends_txn_chk: assert property (@(posedge clk) disable iff (rst)
        berr_q |-> !active_q);

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active_q |-> cnt_q <= last_q);

    // R8
    limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q)) |-> $stable(last_q));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !fin && cnt_q != last_q) |=> (active_q && cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import bmon_pkg::*;
#(
    parameter int unsigned BASE_CLOCKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] tmo_sel,
    input  logic       ext_watch_en,
    input  logic       cyc_start,
    input  logic       cyc_ext,
    input  logic       cyc_by_cpu,
    input  logic       cyc_word,
    input  logic       port_8bit,
    input  logic       ack,
    input  logic       autovec,
    output logic       berr
);

    logic     take;
    logic     load;
    logic     active;
    logic     split;
    logic     fin;
    txn_cfg_t cfg;

    bmon_admit u_admit (
        .cyc_start    (cyc_start),
        .cyc_ext      (cyc_ext),
        .cyc_by_cpu   (cyc_by_cpu),
        .ext_watch_en (ext_watch_en),
        .cyc_word     (cyc_word),
        .port_8bit    (port_8bit),
        .tmo_sel      (tmo_sel),
        .take         (take),
        .cfg          (cfg)
    );

    bmon_timer #(.BASE_CLOCKS(BASE_CLOCKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .cfg    (cfg),
        .fin    (fin),
        .active (active),
        .load   (load),
        .split  (split),
        .berr   (berr)
    );

    bmon_pair_track u_pair (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .active  (active),
        .split   (split),
        .ack     (ack),
        .autovec (autovec),
        .fin     (fin)
    );

    // R6
    other_master_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_ext && !cyc_by_cpu && !active) |=> !active);

    // R5
    ext_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cyc_ext && !ext_watch_en && !active) |=> !active);

    // R4
    internal_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !cyc_ext && !active) |=> active);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !berr);

endmodule

// File: tb/tb_bus_watchdog.sv
`timescale 1ns/1ps
module tb_bus_watchdog;

    localparam int BASE = 8;
    localparam int WIN  = 75;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tmo_sel = 2'b00;
    logic       ext_watch_en = 1'b0;
    logic       cyc_start = 1'b0;
    logic       cyc_ext = 1'b0;
    logic       cyc_by_cpu = 1'b0;
    logic       cyc_word = 1'b0;
    logic       port_8bit = 1'b0;
    logic       ack = 1'b0;
    logic       autovec = 1'b0;
    logic       berr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_watchdog #(.BASE_CLOCKS(BASE)) dut (
        .clk          (clk),
        .rst          (rst),
        .tmo_sel      (tmo_sel),
        .ext_watch_en (ext_watch_en),
        .cyc_start    (cyc_start),
        .cyc_ext      (cyc_ext),
        .cyc_by_cpu   (cyc_by_cpu),
        .cyc_word     (cyc_word),
        .port_8bit    (port_8bit),
        .ack          (ack),
        .autovec      (autovec),
        .berr         (berr)
    );

    function automatic int lim_of(input int sel);
        return BASE << (3 - sel);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // a1/a2: edges of the acks, av: autovector edge, resel: edge where tmo_sel flips,
    // restart: edge where an extra start strobe is injected (0 = none).
    task automatic run_txn(input string req, input int sel, input bit ext, input bit cpu,
                           input bit en, input bit word, input bit p8,
                           input int a1, input int a2, input int av,
                           input int resel, input int restart);
        int  lim;
        bit  mon;
        bit  split;
        int  term;
        int  norm;
        int  exp_first;
        int  first;
        int  pulses;
        lim   = lim_of(sel);
        mon   = !ext || (cpu && en);
        split = word && p8;
        norm  = split ? a2 : a1;
        term  = norm;
        if (av != 0 && (term == 0 || av < term)) term = av;
        exp_first = (mon && (term == 0 || term > lim)) ? lim : 0;
        first  = 0;
        pulses = 0;
        @(negedge clk);
        tmo_sel = sel[1:0]; cyc_ext = ext; cyc_by_cpu = cpu; ext_watch_en = en;
        cyc_word = word; port_8bit = p8; cyc_start = 1'b1; ack = 1'b0; autovec = 1'b0;
        for (int k = 1; k <= WIN; k++) begin
            @(negedge clk);
            if (k >= 2 && berr) begin
                pulses++;
                if (first == 0) first = k - 1;
            end
            cyc_start = (k == restart);
            if (k == restart) begin cyc_ext = 1'b0; cyc_by_cpu = 1'b1; end
            ack     = (k == a1) || (k == a2);
            autovec = (k == av);
            if (k == resel) tmo_sel = tmo_sel ^ 2'b11;
        end
        cyc_start = 1'b0; ack = 1'b0; autovec = 1'b0;
        check(req, "error edge", first, exp_first);
        // R3 one pulse per transaction
        check(req, "pulse count", pulses, exp_first != 0 ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "berr in reset", int'(berr), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2 sweep of all codes and response positions (internal, R4 too)
        for (int s = 0; s < 4; s++) begin
            int L;
            L = lim_of(s);
            run_txn("R1", s, 0, 1, 0, 0, 0, 0,     0, 0, 0, 0);
            run_txn("R1", s, 0, 1, 0, 0, 0, L + 1, 0, 0, 0, 0);
            run_txn("R2", s, 0, 1, 0, 0, 0, L,     0, 0, 0, 0);
            run_txn("R2", s, 0, 1, 0, 0, 0, L - 1, 0, 0, 0, 0);
            run_txn("R2", s, 0, 1, 0, 0, 0, 1,     0, 0, 0, 0);
        end

        // R4 internal cycle from another master, enable off
        run_txn("R4", 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R5 external processor cycle, enable on / off
        run_txn("R5", 2, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        run_txn("R5", 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        run_txn("R5", 2, 1, 1, 1, 0, 0, 16, 0, 0, 0, 0);
        // R6 external cycle from another master, enable on / off
        run_txn("R6", 3, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        run_txn("R6", 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R7 split byte pair: halves 5+5 exceed 8, halves 3+4 fit
        run_txn("R7", 3, 0, 1, 0, 1, 1, 5, 10, 0, 0, 0);
        run_txn("R7", 3, 0, 1, 0, 1, 1, 3, 7,  0, 0, 0);
        run_txn("R7", 3, 0, 1, 0, 1, 1, 5, 0,  0, 0, 0);
        run_txn("R7", 3, 0, 1, 0, 1, 1, 4, 8,  0, 0, 0);
        // R7 word to a wide port ends on one ack; byte to 8-bit port too
        run_txn("R7", 3, 0, 1, 0, 1, 0, 5, 0,  0, 0, 0);
        run_txn("R7", 3, 0, 1, 0, 0, 1, 5, 0,  0, 0, 0);

        // R11 autovector ends a split transfer after its first half
        run_txn("R11", 3, 0, 1, 0, 1, 1, 3, 0, 6, 0, 0);
        run_txn("R11", 2, 0, 1, 0, 0, 0, 0, 0, 16, 0, 0);

        // R8 code change mid-count
        run_txn("R8", 3, 0, 1, 0, 0, 0, 0, 0, 0, 2, 0);
        run_txn("R8", 0, 0, 1, 0, 0, 0, 0, 0, 0, 2, 0);

        // R9 stray start strobe during a count
        run_txn("R9", 3, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4);
        run_txn("R9", 2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 10);

        // R10 reset inside a transaction
        @(negedge clk);
        tmo_sel = 2'b11; cyc_ext = 1'b0; cyc_by_cpu = 1'b1; cyc_start = 1'b1;
        cyc_word = 1'b0; port_8bit = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", "berr during reset", int'(berr), 0);
        rst = 1'b0;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (berr) cnt++;
        end
        check("R10", "pulses after reset", cnt, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule